// File: doc/BRIEF.md
# Program Counter Arbitration Controller

This block is the status and control core of a small 16-bit machine. It owns two address counters: the ordinary program counter and a firmware counter. It also decides which of the two drives the address bus. Each fetched word is classified by its most significant bit. A word with that bit clear is handed to instruction decode through a one-cycle strobe. A word with that bit set is treated as a jump into firmware. Its low 15 bits seed the firmware counter, and an instruction-mode flag keeps the firmware counter on the bus until a return strobe gives control back to the program counter.

Advance of the owning counter is gated by a halt flag and an input-mode flag. While the machine is running, the owning counter steps every clock. While it is halted, one front-panel step press yields exactly one advance. Input mode suppresses all advance so that the panel can load memory. Three sources can force the halt flag: the panel, a halt instruction and an error line. The block also keeps a carry flag captured from the ALU's 17th result bit.

Top module: `pca_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge the block enters this state: `halted`=1, `input_mode`=0, `instr_mode`=0, `carry_flag`=0, `owner`=4'h0, both counters 0, and `pc_inc_en`, `fw_inc_en` and `decode_valid` all 0.
- R2: A `word_valid` cycle whose word has bit 15 = 0 raises `decode_valid` for exactly the next cycle, with `decode_word` equal to that word. It changes neither the owner nor the flags.
- R3: A `word_valid` cycle whose word has bit 15 = 1 causes the following changes in the next cycle: `fw_addr` equals word bits 14:0, `instr_mode`=1 and `owner`=4'h1, and `addr_out` shows the firmware counter. `decode_valid` stays 0. This load takes priority over any firmware-counter increment in the same cycle.
- R4: `ret_strobe` while `instr_mode`=1 causes the following changes in the next cycle: `instr_mode`=0, `owner`=4'h0, and `addr_out` shows the program counter. `ret_strobe` has no effect while `instr_mode`=0. If a call word and `ret_strobe` arrive in the same cycle, the call wins.
- R5: `owner` only ever takes the codes 4'h0 (program counter) or 4'h1 (firmware counter).
- R6: An advance tick increments only the counter that `owner` names, by 1, wrapping from 15'h7FFF to 0. That counter's increment enable (`pc_inc_en` or `fw_inc_en`) is high in exactly the cycle in which the new count appears. The two enables are never high together.
- R7: When `halted`=1 and `input_mode`=0, a rising edge on `step_btn` gives exactly one tick, however long the button is held. The new count is visible after the third clock edge that samples the button high.
- R8: In any cycle that follows one with `input_mode`=1, neither counter advances, whether the machine is running or being stepped. `input_mode` follows `panel_input` with one cycle of delay.
- R9: Any of `panel_halt`, `halt_instr` or `err_in` sets `halted` in the next cycle. `panel_run` clears it only when none of the three setting sources is active.
- R10: When `alu_valid`=1, `carry_flag` takes the value of `alu_cout` in the next cycle. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_btn | input | 1 | Raw single-step button, asynchronous |
| panel_halt | input | 1 | Front-panel halt request |
| panel_run | input | 1 | Front-panel run request |
| panel_input | input | 1 | Front-panel input-mode level |
| err_in | input | 1 | Error condition, forces halt |
| halt_instr | input | 1 | Halt instruction strobe |
| word_valid | input | 1 | Fetched word present |
| word_in | input | 16 | Fetched word |
| ret_strobe | input | 1 | Return instruction strobe |
| alu_valid | input | 1 | ALU result present |
| alu_cout | input | 1 | Bit 16 of the ALU result |
| owner | output | 4 | Active-counter code (0 program, 1 firmware) |
| addr_out | output | 15 | Address from the owning counter |
| pc_addr | output | 15 | Program counter |
| fw_addr | output | 15 | Firmware counter |
| pc_inc_en | output | 1 | Program counter advanced this cycle |
| fw_inc_en | output | 1 | Firmware counter advanced this cycle |
| decode_valid | output | 1 | Word for decode present |
| decode_word | output | 16 | Word handed to decode |
| halted | output | 1 | Halt flag |
| input_mode | output | 1 | Input-mode flag |
| instr_mode | output | 1 | Firmware-control flag |
| carry_flag | output | 1 | Carry flag |

## Verification
The flags, the decode strobe, call loads and returns all show up one clock after their input. A counter step and its enable appear together, one clock after the tick condition. A step press reaches the counter on the third edge after the button is first sampled high. The bench drives inputs on falling edges and samples on falling edges. A cycle model that applies these latencies is compared field by field every cycle. Directed checks wait the exact number of edges given above before they read literal expected values.

// File: rtl/pca_pkg.sv
package pca_pkg;
  typedef enum logic [3:0] {
    OWN_PC = 4'h0,
    OWN_FW = 4'h1
  } owner_e;
endpackage

// File: rtl/pca_step_sync.sv
module pca_step_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic step_pulse
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= btn_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[TOP-1:0], btn_raw};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[TOP];
  end

  assign step_pulse = sync_q[TOP] & ~prev_q;
endmodule

// File: rtl/pca_flags.sv
module pca_flags (
  input  logic clk,
  input  logic rst,
  input  logic panel_halt,
  input  logic panel_run,
  input  logic halt_instr,
  input  logic err_in,
  input  logic panel_input,
  input  logic alu_valid,
  input  logic alu_cout,
  output logic halted_q,
  output logic input_q,
  output logic carry_q
);
  logic halt_req;
  assign halt_req = panel_halt | halt_instr | err_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b1;
      input_q  <= 1'b0;
      carry_q  <= 1'b0;
    end else begin
      if (halt_req)       halted_q <= 1'b1;
      else if (panel_run) halted_q <= 1'b0;
      input_q <= panel_input;
      if (alu_valid) carry_q <= alu_cout;
    end
  end
endmodule

// File: rtl/pca_counters.sv
module pca_counters
  import pca_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             call,
  input  logic             ret,
  input  logic [CNT_W-1:0] call_addr,
  output owner_e           owner_q,
  output logic             mode_q,
  output logic [CNT_W-1:0] pc_q,
  output logic [CNT_W-1:0] fw_q,
  output logic             pc_inc_q,
  output logic             fw_inc_q
);
  logic ret_ok;
  logic pc_turn;
  logic fw_turn;

  assign ret_ok  = ret & mode_q & ~call;
  assign pc_turn = tick & (owner_q == OWN_PC);
  assign fw_turn = tick & (owner_q == OWN_FW) & ~call;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q  <= OWN_PC;
      mode_q   <= 1'b0;
      pc_q     <= '0;
      fw_q     <= '0;
      pc_inc_q <= 1'b0;
      fw_inc_q <= 1'b0;
    end else begin
      pc_inc_q <= pc_turn;
      fw_inc_q <= fw_turn;
      if (pc_turn) pc_q <= pc_q + 1'b1;
      if (call)         fw_q <= call_addr;
      else if (fw_turn) fw_q <= fw_q + 1'b1;
      if (call) begin
        mode_q  <= 1'b1;
        owner_q <= OWN_FW;
      end else if (ret_ok) begin
        mode_q  <= 1'b0;
        owner_q <= OWN_PC;
      end
    end
  end
endmodule

// File: rtl/pca_ctrl.sv
module pca_ctrl
  import pca_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_btn,
  input  logic              panel_halt,
  input  logic              panel_run,
  input  logic              panel_input,
  input  logic              err_in,
  input  logic              halt_instr,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  input  logic              ret_strobe,
  input  logic              alu_valid,
  input  logic              alu_cout,
  output logic [3:0]        owner,
  output logic [WORD_W-2:0] addr_out,
  output logic [WORD_W-2:0] pc_addr,
  output logic [WORD_W-2:0] fw_addr,
  output logic              pc_inc_en,
  output logic              fw_inc_en,
  output logic              decode_valid,
  output logic [WORD_W-1:0] decode_word,
  output logic              halted,
  output logic              input_mode,
  output logic              instr_mode,
  output logic              carry_flag
);
  localparam int CNT_W = WORD_W - 1;

  logic   step_pulse;
  logic   tick;
  logic   is_call;
  logic   is_decode;
  owner_e owner_q;

  pca_step_sync #(.SYNC_STAGES(SYNC_STAGES)) u_step (
    .clk        (clk),
    .rst        (rst),
    .btn_raw    (step_btn),
    .step_pulse (step_pulse)
  );

  pca_flags u_flags (
    .clk         (clk),
    .rst         (rst),
    .panel_halt  (panel_halt),
    .panel_run   (panel_run),
    .halt_instr  (halt_instr),
    .err_in      (err_in),
    .panel_input (panel_input),
    .alu_valid   (alu_valid),
    .alu_cout    (alu_cout),
    .halted_q    (halted),
    .input_q     (input_mode),
    .carry_q     (carry_flag)
  );

  assign tick      = (~halted | step_pulse) & ~input_mode;
  assign is_call   = word_valid &  word_in[WORD_W-1];
  assign is_decode = word_valid & ~word_in[WORD_W-1];

  pca_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .call      (is_call),
    .ret       (ret_strobe),
    .call_addr (word_in[CNT_W-1:0]),
    .owner_q   (owner_q),
    .mode_q    (instr_mode),
    .pc_q      (pc_addr),
    .fw_q      (fw_addr),
    .pc_inc_q  (pc_inc_en),
    .fw_inc_q  (fw_inc_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      decode_valid <= 1'b0;
      decode_word  <= '0;
    end else begin
      decode_valid <= is_decode;
      if (is_decode) decode_word <= word_in;
    end
  end

  assign owner    = owner_q;
  assign addr_out = (owner_q == OWN_FW) ? fw_addr : pc_addr;
endmodule

// File: rtl/pca_ctrl_chk.sv
module pca_ctrl_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        owner,
  input logic              instr_mode,
  input logic [CNT_W-1:0]  pc_addr,
  input logic [CNT_W-1:0]  fw_addr,
  input logic              pc_inc_en,
  input logic              fw_inc_en,
  input logic              decode_valid,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_in,
  input logic              ret_strobe,
  input logic              halted,
  input logic              input_mode,
  input logic              panel_halt,
  input logic              panel_run,
  input logic              halt_instr,
  input logic              err_in
);
  // R5
  owner_code_chk: assert property (@(posedge clk) disable iff (rst)
    (owner == 4'h0) || (owner == 4'h1));

  // R2
  decode_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_in[WORD_W-1]) |=> decode_valid);

  // R2
  decode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(word_valid && !word_in[WORD_W-1]) |=> !decode_valid);

  // R3
  call_load_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_in[WORD_W-1]) |=>
      (instr_mode && owner == 4'h1 && fw_addr == $past(word_in[CNT_W-1:0])));

  // R4
  return_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_strobe && instr_mode && !(word_valid && word_in[WORD_W-1])) |=>
      (!instr_mode && owner == 4'h0));

  // R6
  single_inc_chk: assert property (@(posedge clk) disable iff (rst)
    !(pc_inc_en && fw_inc_en));

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    pc_inc_en |-> (pc_addr == CNT_W'($past(pc_addr) + 1'b1)));

  // R8
  input_block_chk: assert property (@(posedge clk) disable iff (rst)
    input_mode |=> (!pc_inc_en && !fw_inc_en));

  // R9
  halt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (panel_halt || halt_instr || err_in) |=> halted);

  // R9
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (panel_run && !panel_halt && !halt_instr && !err_in) |=> !halted);
endmodule

bind pca_ctrl pca_ctrl_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .owner        (owner),
  .instr_mode   (instr_mode),
  .pc_addr      (pc_addr),
  .fw_addr      (fw_addr),
  .pc_inc_en    (pc_inc_en),
  .fw_inc_en    (fw_inc_en),
  .decode_valid (decode_valid),
  .word_valid   (word_valid),
  .word_in      (word_in),
  .ret_strobe   (ret_strobe),
  .halted       (halted),
  .input_mode   (input_mode),
  .panel_halt   (panel_halt),
  .panel_run    (panel_run),
  .halt_instr   (halt_instr),
  .err_in       (err_in)
);

// File: tb/pca_ctrl_tb.sv
module pca_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int RAND_CYC   = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 0, ph = 0, pr = 0, pim = 0, err = 0, hi = 0;
  logic wv = 0, rs = 0, av = 0, ac = 0;
  logic [15:0] w = '0;

  logic [3:0]  owner;
  logic [14:0] addr_out, pc_addr, fw_addr;
  logic        pc_inc_en, fw_inc_en, decode_valid;
  logic [15:0] decode_word;
  logic        halted, input_mode, instr_mode, carry_flag;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pca_ctrl u_dut (
    .clk(clk), .rst(rst), .step_btn(btn), .panel_halt(ph), .panel_run(pr),
    .panel_input(pim), .err_in(err), .halt_instr(hi), .word_valid(wv),
    .word_in(w), .ret_strobe(rs), .alu_valid(av), .alu_cout(ac),
    .owner(owner), .addr_out(addr_out), .pc_addr(pc_addr), .fw_addr(fw_addr),
    .pc_inc_en(pc_inc_en), .fw_inc_en(fw_inc_en), .decode_valid(decode_valid),
    .decode_word(decode_word), .halted(halted), .input_mode(input_mode),
    .instr_mode(instr_mode), .carry_flag(carry_flag)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // cycle model built from the requirement latencies
  logic [3:0]  m_owner;
  logic        m_mode, m_halt, m_inm, m_carry, m_pinc, m_finc, m_dv;
  logic [14:0] m_pc, m_fw;
  logic [15:0] m_dw;
  logic        m_s0, m_s1, m_prev;

  always @(posedge clk) begin
    if (rst) begin
      m_owner = 4'h0; m_mode = 0; m_halt = 1; m_inm = 0; m_carry = 0;
      m_pinc = 0; m_finc = 0; m_dv = 0; m_pc = '0; m_fw = '0; m_dw = '0;
      m_s0 = 0; m_s1 = 0; m_prev = 0;
    end else begin
      logic stp, tk, cl, dc, rt;
      stp = m_s1 & ~m_prev;
      tk  = (~m_halt | stp) & ~m_inm;
      cl  = wv & w[15];
      dc  = wv & ~w[15];
      rt  = rs & m_mode & ~cl;
      m_pinc = tk & (m_owner == 4'h0);
      m_finc = tk & (m_owner == 4'h1) & ~cl;
      if (m_pinc) m_pc = m_pc + 15'd1;
      if (cl) m_fw = w[14:0];
      else if (m_finc) m_fw = m_fw + 15'd1;
      if (cl) begin m_mode = 1; m_owner = 4'h1; end
      else if (rt) begin m_mode = 0; m_owner = 4'h0; end
      m_dv = dc;
      if (dc) m_dw = w;
      if (ph | hi | err) m_halt = 1;
      else if (pr) m_halt = 0;
      m_inm = pim;
      if (av) m_carry = ac;
      m_prev = m_s1; m_s1 = m_s0; m_s0 = btn;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R5", "owner", owner, m_owner);
      chk("R3", "instr_mode", instr_mode, m_mode);
      chk("R6", "pc_addr", pc_addr, m_pc);
      chk("R6", "fw_addr", fw_addr, m_fw);
      chk("R6", "pc_inc_en", pc_inc_en, m_pinc);
      chk("R6", "fw_inc_en", fw_inc_en, m_finc);
      chk("R4", "addr_out", addr_out, (m_owner == 4'h1) ? m_fw : m_pc);
      chk("R2", "decode_valid", decode_valid, m_dv);
      if (m_dv) chk("R2", "decode_word", decode_word, m_dw);
      chk("R9", "halted", halted, m_halt);
      chk("R8", "input_mode", input_mode, m_inm);
      chk("R10", "carry_flag", carry_flag, m_carry);
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    int seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cmp_on = 1;
    // R1 reset state
    chk("R1", "halted", halted, 1);
    chk("R1", "owner", owner, 0);
    chk("R1", "counters", {pc_addr, fw_addr}, 0);
    chk("R1", "flags", {input_mode, instr_mode, carry_flag, decode_valid, pc_inc_en, fw_inc_en}, 0);

    // R7 one press gives one step
    btn = 1; seen = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); seen += pc_inc_en; end
    chk("R7", "step count", seen, 1);
    chk("R7", "pc after press", pc_addr, 1);
    btn = 0; repeat (4) @(negedge clk);

    // R8 input mode blocks stepping
    pim = 1; @(negedge clk);
    btn = 1; repeat (6) @(negedge clk);
    chk("R8", "pc held", pc_addr, 1);
    btn = 0; pim = 0; repeat (4) @(negedge clk);

    // R3 call with top address
    wv = 1; w = 16'hFFFF; @(negedge clk); wv = 0;
    chk("R3", "fw load", fw_addr, 15'h7FFF);
    chk("R3", "owner fw", owner, 1);
    chk("R3", "addr_out", addr_out, 15'h7FFF);
    chk("R3", "no decode", decode_valid, 0);

    // R6 wrap of the firmware counter on one step
    btn = 1; repeat (5) @(negedge clk);
    chk("R6", "fw wrap", fw_addr, 0);
    chk("R6", "pc untouched", pc_addr, 1);
    btn = 0; repeat (4) @(negedge clk);

    // R2 decode path
    wv = 1; w = 16'h1234; @(negedge clk); wv = 0;
    chk("R2", "decode strobe", decode_valid, 1);
    chk("R2", "decode data", decode_word, 16'h1234);
    chk("R2", "owner kept", owner, 1);
    @(negedge clk);
    chk("R2", "strobe one cycle", decode_valid, 0);

    // R4 return, then ignored return
    rs = 1; @(negedge clk); rs = 0;
    chk("R4", "owner pc", owner, 0);
    chk("R4", "addr from pc", addr_out, 1);
    rs = 1; @(negedge clk); rs = 0;
    chk("R4", "ignored ret owner", {owner, instr_mode}, 0);
    chk("R4", "ignored ret pc", pc_addr, 1);

    // R4 call and return together: call wins
    wv = 1; w = 16'h8005; rs = 1; @(negedge clk); wv = 0; rs = 0;
    chk("R4", "call beats ret", {owner, fw_addr}, {4'h1, 15'd5});
    rs = 1; @(negedge clk); rs = 0;

    // R10 carry capture
    av = 1; ac = 1; @(negedge clk);
    chk("R10", "carry set", carry_flag, 1);
    ac = 0; @(negedge clk); av = 0;
    chk("R10", "carry clear", carry_flag, 0);

    // R9 halt sources and priority, R6 running count
    pr = 1; @(negedge clk); pr = 0;
    chk("R9", "run clears", halted, 0);
    p0 = pc_addr;
    repeat (5) @(negedge clk);
    chk("R6", "running count", pc_addr, 15'(p0 + 5));
    err = 1; @(negedge clk); err = 0;
    chk("R9", "error halts", halted, 1);
    pr = 1; hi = 1; @(negedge clk); pr = 0; hi = 0;
    chk("R9", "set beats run", halted, 1);

    // constrained random phase
    for (int c = 0; c < RAND_CYC; c++) begin
      wv  = ($urandom % 10) < 3;
      w   = 16'($urandom);
      rs  = ($urandom % 8) == 0;
      ph  = ($urandom % 40) == 0;
      pr  = ($urandom % 8) == 0;
      hi  = ($urandom % 60) == 0;
      err = ($urandom % 100) == 0;
      pim = ($urandom % 12) == 0;
      av  = ($urandom % 4) == 0;
      ac  = 1'($urandom);
      if (($urandom % 6) == 0) btn = ~btn;
      @(negedge clk);
    end
    {wv, rs, ph, pr, hi, err, pim, av, btn} = '0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule